// File: doc/BRIEF.md
# Half-to-Single Precision Widener

This block turns a 16-bit IEEE 754 binary16 value into the binary32 value of the same number. It does this by taking the fields apart and building new ones, not by doing arithmetic. Every binary16 value can be written exactly in binary32, so the block never rounds and raises no exception flags. Infinities, quiet NaNs and signaling NaNs pass through with their payload bits in place. The quiet bit of a signaling NaN therefore stays clear, and a later NaN-selection stage can still tell signaling NaNs from quiet ones.

A binary16 subnormal is normally renormalized into an ordinary binary32 normal number. The block finds the leading one of the fraction, removes it as the hidden bit, and lowers the exponent by the same amount. When the flush control input is high, a subnormal input instead becomes a zero that keeps the input's sign. By default the result is captured in an output register qualified by a valid bit. Setting the `REG_OUT` parameter to 0 makes the block purely combinational.

Top module: `h2s_widen`

## Requirements
- R1: The output sign bit 31 always equals input sign bit 15, in every class and with the flush control high or low. Input fields are sign [15], exponent [14:10] and fraction [9:0]. Output fields are sign [31], exponent [30:23] and fraction [22:0].
- R2: When the input exponent is 31, the output exponent is 255 and output bits [22:13] equal input fraction bits [9:0]. A signaling NaN (for example 0x7C01) keeps bit 22 clear, so 0x7C01 gives 0x7F802000.
- R3: An input with exponent 0 and fraction 0 gives a zero of the same sign: 0x00000000 or 0x80000000.
- R4: When the flush control is 1, an input with exponent 0 and a nonzero fraction gives a zero that keeps the input sign.
- R5: When the flush control is 0, an input with exponent 0 and a nonzero fraction whose highest set bit is at position p (0..9) gives output exponent 103+p. The output fraction bits [22:13] are the input fraction shifted left by 10−p and masked to 10 bits. For example, 0x0001 gives 0x33800000.
- R6: An input with exponent e in 1..30 gives output exponent e+112 and output bits [22:13] equal to the input fraction.
- R7: Output bits [12:0] are always zero.
- R8: With `REG_OUT`=1, `out_valid` is high exactly one cycle after `in_valid` was high, and `out_single` holds the conversion of the input presented with it. While `rst_n` is low, `out_valid` and `out_single` are 0. A cycle with `in_valid` low leaves `out_single` unchanged.
- R9: The flush control has no effect on zero, normal, infinity or NaN inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock (used when REG_OUT=1) |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input qualifier and output register enable |
| in_half | input | 16 | binary16 operand |
| flush_sub | input | 1 | 1: subnormal inputs become signed zero |
| out_valid | output | 1 | Result qualifier |
| out_single | output | 32 | binary32 result |

## Verification
The clocked properties assume the default registered build. They compare each valid output with the input sampled one cycle earlier, so they rely on `in_half` and `flush_sub` being stable at the clock edge whenever `in_valid` is high. The bench changes inputs only on the falling edge. Every one of the 65536 input encodings is swept once with flush low and once with flush high, and all classes reach the checks. Gaps in `in_valid` are inserted to check that an idle cycle holds the register.

// File: rtl/h2s_pkg.sv
package h2s_pkg;
  localparam int HEXP_W    = 5;
  localparam int HFRAC_W   = 10;
  localparam int SEXP_W    = 8;
  localparam int SFRAC_W   = 23;
  localparam int HALF_W    = 1 + HEXP_W + HFRAC_W;
  localparam int SINGLE_W  = 1 + SEXP_W + SFRAC_W;
  localparam int HBIAS     = (1 << (HEXP_W - 1)) - 1;
  localparam int SBIAS     = (1 << (SEXP_W - 1)) - 1;
  localparam int BIAS_DIFF = SBIAS - HBIAS;
  localparam int FRAC_PAD  = SFRAC_W - HFRAC_W;
  localparam int LZ_W      = $clog2(HFRAC_W + 1);

  typedef enum logic [2:0] {
    CLS_ZERO,
    CLS_FLUSH,
    CLS_SUB,
    CLS_NORM,
    CLS_SPECIAL
  } h2s_cls_e;

  typedef struct packed {
    logic                sign;
    logic [HEXP_W-1:0]   exp;
    logic [HFRAC_W-1:0]  frac;
  } half_t;

  typedef struct packed {
    logic                sign;
    logic [SEXP_W-1:0]   exp;
    logic [SFRAC_W-1:0]  frac;
  } single_t;
endpackage

// File: rtl/h2s_lzc.sv
module h2s_lzc #(
  parameter int WIDTH = 10,
  localparam int CNT_W = $clog2(WIDTH + 1)
) (
  input  logic [WIDTH-1:0] vec,
  output logic [CNT_W-1:0] count,
  output logic             all_zero
);
  logic [WIDTH-1:0] above_clear;

  // above_clear[i]: no bit above position i is set
  genvar g;
  generate
    for (g = 0; g < WIDTH; g++) begin : g_above
      if (g == WIDTH - 1) begin : g_top
        assign above_clear[g] = 1'b1;
      end else begin : g_rest
        assign above_clear[g] = ~|vec[WIDTH-1:g+1];
      end
    end
  endgenerate

  always_comb begin
    count = CNT_W'(WIDTH);
    for (int i = 0; i < WIDTH; i++) begin
      if (vec[i] && above_clear[i]) begin
        count = CNT_W'(WIDTH - 1 - i);
      end
    end
  end

  assign all_zero = ~|vec;
endmodule

// File: rtl/h2s_classify.sv
module h2s_classify
  import h2s_pkg::*;
(
  input  half_t    op,
  input  logic     flush,
  input  logic     frac_zero,
  output h2s_cls_e cls
);
  logic exp_max;
  logic exp_min;

  assign exp_max = &op.exp;
  assign exp_min = ~|op.exp;

  always_comb begin
    if (exp_max) begin
      cls = CLS_SPECIAL;
    end else if (!exp_min) begin
      cls = CLS_NORM;
    end else if (frac_zero) begin
      cls = CLS_ZERO;
    end else if (flush) begin
      cls = CLS_FLUSH;
    end else begin
      cls = CLS_SUB;
    end
  end
endmodule

// File: rtl/h2s_assemble.sv
module h2s_assemble
  import h2s_pkg::*;
(
  input  half_t           op,
  input  h2s_cls_e        cls,
  input  logic [LZ_W-1:0] lz,
  output single_t         res
);
  logic [LZ_W:0]         sub_shift;
  logic [HFRAC_W-1:0]    sub_frac;
  logic [SEXP_W-1:0]     sub_exp;
  logic [SEXP_W-1:0]     norm_exp;

  // leading one moves to the hidden position and is dropped
  assign sub_shift = {1'b0, lz} + (LZ_W+1)'(1);
  assign sub_frac  = op.frac << sub_shift;
  assign sub_exp   = SEXP_W'(BIAS_DIFF) - SEXP_W'(lz);
  assign norm_exp  = SEXP_W'(op.exp) + SEXP_W'(BIAS_DIFF);

  always_comb begin
    res.sign = op.sign;
    res.exp  = '0;
    res.frac = '0;
    unique case (cls)
      CLS_SPECIAL: begin
        res.exp  = '1;
        res.frac = {op.frac, {FRAC_PAD{1'b0}}};
      end
      CLS_NORM: begin
        res.exp  = norm_exp;
        res.frac = {op.frac, {FRAC_PAD{1'b0}}};
      end
      CLS_SUB: begin
        res.exp  = sub_exp;
        res.frac = {sub_frac, {FRAC_PAD{1'b0}}};
      end
      default: begin
        res.exp  = '0;
        res.frac = '0;
      end
    endcase
  end
endmodule

// File: rtl/h2s_widen.sv
module h2s_widen
  import h2s_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [HALF_W-1:0]   in_half,
  input  logic                flush_sub,
  output logic                out_valid,
  output logic [SINGLE_W-1:0] out_single
);
  half_t           op;
  h2s_cls_e        cls;
  logic [LZ_W-1:0] lz;
  logic            frac_zero;
  single_t         res;

  assign op = half_t'(in_half);

  h2s_lzc #(.WIDTH(HFRAC_W)) u_lzc (
    .vec      (op.frac),
    .count    (lz),
    .all_zero (frac_zero)
  );

  h2s_classify u_cls (
    .op        (op),
    .flush     (flush_sub),
    .frac_zero (frac_zero),
    .cls       (cls)
  );

  h2s_assemble u_asm (
    .op  (op),
    .cls (cls),
    .lz  (lz),
    .res (res)
  );

  generate
    if (REG_OUT) begin : g_reg
      logic                vld_d, vld_q;
      logic [SINGLE_W-1:0] data_d, data_q;

      always_comb begin
        vld_d  = in_valid;
        data_d = data_q;
        if (in_valid) begin
          data_d = SINGLE_W'(res);
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          vld_q  <= 1'b0;
          data_q <= '0;
        end else begin
          vld_q  <= vld_d;
          data_q <= data_d;
        end
      end

      assign out_valid  = vld_q;
      assign out_single = data_q;

      a_r1_sign: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_single[SINGLE_W-1] == $past(in_half[HALF_W-1]));

      a_r2_special_exp: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(&in_half[HALF_W-2 -: HEXP_W])) |->
        (&out_single[SINGLE_W-2 -: SEXP_W]) &&
        out_single[SFRAC_W-1 -: HFRAC_W] == $past(in_half[HFRAC_W-1:0]));

      a_r4_flush_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(flush_sub) && $past(in_half[HALF_W-2 -: HEXP_W] == '0)) |->
        out_single[SINGLE_W-2:0] == '0);

      a_r6_normal_exp: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(in_half[HALF_W-2 -: HEXP_W] != '0) &&
         $past(~&in_half[HALF_W-2 -: HEXP_W])) |->
        out_single[SINGLE_W-2 -: SEXP_W] ==
        SEXP_W'($past(in_half[HALF_W-2 -: HEXP_W])) + SEXP_W'(BIAS_DIFF));

      a_r7_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
        out_single[FRAC_PAD-1:0] == '0);

      a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(in_valid) |-> $stable(out_single));

      a_r8_follow: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(in_valid));
    end else begin : g_comb
      assign out_valid  = in_valid;
      assign out_single = SINGLE_W'(res);

      a_r7_low_zero_c: assert property (@(posedge clk) disable iff (!rst_n)
        out_single[FRAC_PAD-1:0] == '0);

      a_r1_sign_c: assert property (@(posedge clk) disable iff (!rst_n)
        out_single[SINGLE_W-1] == in_half[HALF_W-1]);

      a_r2_special_c: assert property (@(posedge clk) disable iff (!rst_n)
        (&in_half[HALF_W-2 -: HEXP_W]) |-> (&out_single[SINGLE_W-2 -: SEXP_W]));

      a_r4_flush_c: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_sub && in_half[HALF_W-2 -: HEXP_W] == '0) |->
        out_single[SINGLE_W-2:0] == '0);
    end
  endgenerate
endmodule

// File: tb/h2s_widen_tb.sv
module h2s_widen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  typedef struct {
    logic [31:0] value;
    logic [15:0] src;
    logic        flush;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [15:0] in_half;
  logic        flush_sub;
  logic        out_valid;
  logic [31:0] out_single;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  exp_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  h2s_widen u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_half    (in_half),
    .flush_sub  (flush_sub),
    .out_valid  (out_valid),
    .out_single (out_single)
  );

  // reference model written from the requirements
  function automatic logic [31:0] ref_conv(input logic [15:0] h, input logic f);
    logic       s;
    logic [4:0] e;
    logic [9:0] m;
    int         p;
    s = h[15]; e = h[14:10]; m = h[9:0];
    if (e == 5'd31) return {s, 8'hff, m, 13'b0};
    if (e != 5'd0)  return {s, 8'(int'(e) + 112), m, 13'b0};
    if (m == 10'd0 || f) return {s, 31'b0};
    p = 0;
    for (int i = 0; i < 10; i++) if (m[i]) p = i;
    return {s, 8'(103 + p), 10'(m << (10 - p)), 13'b0};
  endfunction

  function automatic string req_of(input logic [15:0] h, input logic f);
    if (h[14:10] == 5'd31) return f ? "R9/R2" : "R2";
    if (h[14:10] != 5'd0)  return f ? "R9/R6" : "R6";
    if (h[9:0] == 10'd0)   return f ? "R9/R3" : "R3";
    return f ? "R4" : "R5";
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  task automatic drive(input logic [15:0] h, input logic f);
    exp_t item;
    @(negedge clk);
    in_valid  = 1'b1;
    in_half   = h;
    flush_sub = f;
    item.value = ref_conv(h, f);
    item.src   = h;
    item.flush = f;
    sb_q.push_back(item);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid  = 1'b0;
    in_half   = 16'hdead;
    flush_sub = 1'b0;
  endtask

  // monitor: sample just after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (rst_n && out_valid) begin
        if (sb_q.size() == 0) begin
          check("R8 unexpected valid", 32'(out_valid), 32'd0);
        end else begin
          exp_t it;
          it = sb_q.pop_front();
          check(req_of(it.src, it.flush), out_single, it.value);
          check("R1 sign", {31'b0, out_single[31]}, {31'b0, it.src[15]});
          check("R7 low bits", {19'b0, out_single[12:0]}, 32'd0);
        end
      end
    end
  end

  initial begin
    logic [31:0] held;
    rst_n = 1'b0; in_valid = 1'b0; in_half = '0; flush_sub = 1'b0;
    repeat (3) @(negedge clk);
    check("R8 reset valid", {31'b0, out_valid}, 32'd0);
    check("R8 reset data", out_single, 32'd0);
    rst_n = 1'b1;

    // directed corners
    drive(16'h0001, 1'b0);  // R5 smallest subnormal -> 0x33800000
    drive(16'h7C01, 1'b0);  // R2 signaling NaN keeps quiet bit clear
    drive(16'h7E00, 1'b0);  // R2 quiet NaN
    drive(16'hFC00, 1'b0);  // R2 -inf
    drive(16'h8000, 1'b0);  // R3 -0
    drive(16'h83FF, 1'b0);  // R5 largest negative subnormal
    drive(16'h83FF, 1'b1);  // R4 flushed, sign kept
    drive(16'h7BFF, 1'b1);  // R9 max normal unaffected by flush
    drive(16'h7C01, 1'b1);  // R9 NaN unaffected by flush
    idle();
    @(posedge clk); #1;
    check("R8 idle valid low", {31'b0, out_valid}, 32'd0);
    held = out_single;
    idle();
    @(posedge clk); #1;
    check("R8 idle holds data", out_single, held);

    // full sweeps with gaps
    for (int fl = 0; fl < 2; fl++) begin
      for (int v = 0; v < 65536; v++) begin
        drive(16'(v), fl[0]);
        if ((v % 4099) == 0) idle();
      end
    end
    idle();
    repeat (3) @(negedge clk);
    check("R8 queue drained", 32'(sb_q.size()), 32'd0);
    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (WATCHDOG) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule